// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns an incoming clock-enable (a one-cycle tick) into a slower train of one-cycle output pulses. The pulses act as the count enable of a baud rate timer. An 8-bit result register holds the divider's state. The block has two modes, chosen by one select bit.

- **Fractional mode** (select = 0): every input tick adds a programmable step to the register. An output pulse is issued on each addition that carries out of bit 7. The average output rate is the input rate times step/256.
- **Normal mode** (select = 1): the register counts up by one on every tick. When it passes 0xFF it reloads with the step value and issues a pulse. This divides the tick rate by the integer 256 − step.

The result register is visible on an output port. A load strobe can overwrite it. Clearing the enable holds the register at zero and silences the output.

Top module: `frac_clk_en_div`

## Requirements
- R1: After a synchronous reset the result register reads 0x00 and no output pulse is present.
- R2: While enable is 0, no pulse is produced, the result register is cleared to 0x00 on the next clock, and the load strobe has no effect.
- R3: In fractional mode (mode = 0), with enable high, each input tick stores the low 8 bits of result + step in the result register.
- R4: In fractional mode a pulse is issued exactly on those ticks whose addition exceeds 0xFF. Starting from 0x00, the count over 256·k ticks is step·k, and a step of 0 gives no pulses.
- R5: In normal mode (mode = 1) each tick increments the result register by one. A tick taken while it holds 0xFF instead reloads it with the step value and issues a pulse, so the steady pulse period is 256 − step ticks.
- R6: Output pulses are one clock wide and appear only in cycles where the input tick and enable are both high.
- R7: A change of mode leaves the result register untouched and governs the next tick.
- R8: With enable high, a load strobe writes the load value into the result register and takes priority over a tick in the same cycle, which then issues no pulse.
- R9: With enable high and neither tick nor load asserted, the result register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Input clock-enable, one tick per high cycle |
| en_i | input | 1 | Divider enable |
| mode_i | input | 1 | 0 = fractional step/256, 1 = normal divide by 256 − step |
| step_i | input | 8 | Step / reload value |
| load_i | input | 1 | Strobe that writes load_val_i into the result register |
| load_val_i | input | 8 | Value written on a load |
| pulse_o | output | 1 | Output pulse, one cycle wide |
| res_o | output | 8 | Current result register |

## Verification
Fractional mode is run from zero with steps 0, 1, 3, 128, 177 and 255 over 512 ticks, with idle cycles mixed in. This pattern distinguishes correct carry detection (count = 2·step, register back to zero) from off-by-one or dropped carries, and shows that pulses never appear without a tick. Normal mode is run with steps 0, 1, 128 and 255, and the spacing between consecutive pulses is measured. These four values separate a correct 256 − step reload from a reload to zero or an extra tick per period. Further directed sequences check that a mode switch keeps the accumulated value, that a load overrides a simultaneous tick, and that a disable clears the register and blocks loads.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic {
        FDIV_FRAC = 1'b0,
        FDIV_NORM = 1'b1
    } fdiv_mode_e;

    typedef struct packed {
        logic       en;
        logic       tick;
        logic       load;
        fdiv_mode_e mode;
    } fdiv_ctrl_t;

endpackage

// File: rtl/fdiv_next_calc.sv
module fdiv_next_calc
    import fdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] step_i,
    input  fdiv_mode_e   mode_i,
    output logic [W-1:0] next_o,
    output logic         carry_o
);
    logic [W:0] frac_sum;
    logic [W:0] norm_sum;

    always_comb begin
        frac_sum = {1'b0, res_i} + {1'b0, step_i};
        norm_sum = {1'b0, res_i} + {{W{1'b0}}, 1'b1};
        if (mode_i == FDIV_FRAC) begin
            next_o  = frac_sum[W-1:0];
            carry_o = frac_sum[W];
        end else begin
            carry_o = norm_sum[W];
            next_o  = norm_sum[W] ? step_i : norm_sum[W-1:0];
        end
    end
endmodule

// File: rtl/fdiv_pulse_qual.sv
module fdiv_pulse_qual
    import fdiv_pkg::*;
(
    input  fdiv_ctrl_t ctrl_i,
    input  logic       carry_i,
    output logic       pulse_o
);
    always_comb begin
        pulse_o = ctrl_i.en && ctrl_i.tick && !ctrl_i.load && carry_i;
    end
endmodule

// File: rtl/frac_clk_en_div.sv
module frac_clk_en_div
    import fdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic         mode_i,
    input  logic [W-1:0] step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         pulse_o,
    output logic [W-1:0] res_o
);
    localparam logic [W-1:0] RES_ZERO = '0;

    typedef struct packed {
        logic [W-1:0] res;
    } state_t;

    state_t     state_d;
    state_t     state_q;
    fdiv_ctrl_t ctrl;
    logic [W-1:0] acc_next;
    logic         acc_carry;

    always_comb begin
        ctrl.en   = en_i;
        ctrl.tick = tick_i;
        ctrl.load = load_i;
        ctrl.mode = fdiv_mode_e'(mode_i);
    end

    fdiv_next_calc #(.W(W)) u_calc (
        .res_i   (state_q.res),
        .step_i  (step_i),
        .mode_i  (ctrl.mode),
        .next_o  (acc_next),
        .carry_o (acc_carry)
    );

    fdiv_pulse_qual u_qual (
        .ctrl_i  (ctrl),
        .carry_i (acc_carry),
        .pulse_o (pulse_o)
    );

    always_comb begin
        state_d = state_q;
        if (!ctrl.en) begin
            state_d.res = RES_ZERO;
        end else if (ctrl.load) begin
            state_d.res = load_val_i;
        end else if (ctrl.tick) begin
            state_d.res = acc_next;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q.res <= RES_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o = state_q.res;
endmodule

// File: rtl/frac_clk_en_div_chk.sv
module frac_clk_en_div_chk #(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         tick_i,
    input logic         en_i,
    input logic         mode_i,
    input logic [W-1:0] step_i,
    input logic         load_i,
    input logic [W-1:0] load_val_i,
    input logic         pulse_o,
    input logic [W-1:0] res_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, res_o} + {1'b0, step_i};

    logic       adv_frac;
    logic       adv_norm;
    assign adv_frac = en_i && tick_i && !load_i && !mode_i;
    assign adv_norm = en_i && tick_i && !load_i && mode_i;

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (res_o == '0));

    p_disable_clear_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (res_o == '0));

    p_disable_silent_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> !pulse_o);

    p_frac_sum_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        adv_frac |=> (res_o == $past(wide_sum[W-1:0])));

    p_frac_carry_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        adv_frac |-> (pulse_o == wide_sum[W]));

    p_norm_inc_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_norm && res_o != ALL_ONES) |=> (res_o == $past(res_o) + 1'b1));

    p_norm_reload_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_norm && res_o == ALL_ONES) |-> pulse_o);

    p_norm_reload_val_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_norm && res_o == ALL_ONES) |=> (res_o == $past(step_i)));

    p_pulse_needs_tick_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> (tick_i && en_i));

    p_load_wins_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && load_i) |=> (res_o == $past(load_val_i)));

    p_load_no_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> !pulse_o);

    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !tick_i && !load_i) |=> $stable(res_o));
endmodule

bind frac_clk_en_div frac_clk_en_div_chk #(.W(W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .en_i       (en_i),
    .mode_i     (mode_i),
    .step_i     (step_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .pulse_o    (pulse_o),
    .res_o      (res_o)
);

// File: tb/frac_clk_en_div_tb.sv
module frac_clk_en_div_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] step = 8'd0;
    logic       load = 1'b0;
    logic [7:0] load_val = 8'd0;
    logic       pulse;
    logic [7:0] res;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frac_clk_en_div u_dut (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .en_i(en), .mode_i(mode),
        .step_i(step), .load_i(load), .load_val_i(load_val),
        .pulse_o(pulse), .res_o(res)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, sample pulse mid-cycle, release after edge.
    task automatic cyc(input logic t, input logic ld, output logic p);
        @(negedge clk);
        tick = t;
        load = ld;
        #5 p = pulse;
        @(posedge clk);
        #1;
        tick = 1'b0;
        load = 1'b0;
    endtask

    task automatic clear_div();
        logic p;
        en = 1'b0;
        cyc(1'b0, 1'b0, p);
        en = 1'b1;
    endtask

    task automatic t_reset();
        logic p;
        rst = 1'b1;
        en = 1'b1;
        cyc(1'b0, 1'b0, p);
        cyc(1'b0, 1'b0, p);
        check(res == 8'd0, "R1 reset result", res, 0);
        check(p == 1'b0, "R1 reset pulse", p, 0);
        rst = 1'b0;
    endtask

    task automatic t_frac_count(input logic [7:0] s);
        logic p;
        int cnt = 0;
        clear_div();
        mode = 1'b0;
        step = s;
        for (int i = 0; i < 512; i++) begin
            cyc(1'b1, 1'b0, p);
            cnt += int'(p);
            if (i % 7 == 3) begin
                cyc(1'b0, 1'b0, p);
                check(p == 1'b0, "R6 no pulse without tick", p, 0);
            end
        end
        check(cnt == 2 * int'(s), "R4 fractional pulse count", cnt, 2 * int'(s));
        check(res == 8'd0, "R3 fractional result returns to zero", res, 0);
    endtask

    task automatic t_frac_value();
        logic p;
        clear_div();
        mode = 1'b0;
        step = 8'd200;
        cyc(1'b1, 1'b0, p);
        check(res == 8'd200 && !p, "R3 first add", res, 200);
        cyc(1'b1, 1'b0, p);
        check(res == 8'd144, "R3 low bits kept", res, 144);
        check(p == 1'b1, "R4 carry pulse", p, 1);
        cyc(1'b0, 1'b0, p);
        check(res == 8'd144, "R9 hold without tick", res, 144);
    endtask

    task automatic t_norm_period(input logic [7:0] s);
        logic p;
        int first = -1, second = -1, third = -1;
        clear_div();
        mode = 1'b1;
        step = s;
        for (int i = 1; i <= 800 && third < 0; i++) begin
            cyc(1'b1, 1'b0, p);
            if (p) begin
                if (first < 0) first = i;
                else if (second < 0) second = i;
                else third = i;
            end
        end
        check(first == 256, "R5 first pulse from zero", first, 256);
        check(second - first == 256 - int'(s), "R5 period", second - first, 256 - int'(s));
        check(third - second == 256 - int'(s), "R5 period repeat", third - second, 256 - int'(s));
    endtask

    task automatic t_enable();
        logic p;
        clear_div();
        mode = 1'b0;
        step = 8'd255;
        cyc(1'b1, 1'b0, p);
        cyc(1'b1, 1'b0, p);
        check(res == 8'd254, "R3 pre-disable value", res, 254);
        en = 1'b0;
        load_val = 8'd77;
        cyc(1'b1, 1'b1, p);
        check(p == 1'b0, "R2 no pulse when disabled", p, 0);
        check(res == 8'd0, "R2 disabled clears, load ignored", res, 0);
        cyc(1'b1, 1'b0, p);
        check(p == 1'b0 && res == 8'd0, "R2 stays idle", res, 0);
        en = 1'b1;
    endtask

    task automatic t_mode_switch();
        logic p;
        clear_div();
        mode = 1'b0;
        step = 8'd100;
        cyc(1'b1, 1'b0, p);
        cyc(1'b1, 1'b0, p);
        mode = 1'b1;
        cyc(1'b0, 1'b0, p);
        check(res == 8'd200, "R7 switch keeps result", res, 200);
        cyc(1'b1, 1'b0, p);
        check(res == 8'd201, "R7 normal increments after switch", res, 201);
        mode = 1'b0;
        cyc(1'b1, 1'b0, p);
        check(res == 8'd45, "R7 fractional resumes", res, 45);
        check(p == 1'b1, "R7 carry after switch back", p, 1);
    endtask

    task automatic t_load();
        logic p;
        clear_div();
        mode = 1'b0;
        step = 8'd10;
        load_val = 8'd254;
        cyc(1'b1, 1'b1, p);
        check(p == 1'b0, "R8 load suppresses pulse", p, 0);
        check(res == 8'd254, "R8 load wins over tick", res, 254);
        cyc(1'b1, 1'b0, p);
        check(res == 8'd8 && p == 1'b1, "R8 accumulate from loaded value", res, 8);
        mode = 1'b1;
        step = 8'd128;
        load_val = 8'd255;
        cyc(1'b0, 1'b1, p);
        cyc(1'b1, 1'b0, p);
        check(p == 1'b1 && res == 8'd128, "R5 reload from loaded 0xFF", res, 128);
    endtask

    initial begin
        t_reset();
        t_frac_value();
        t_frac_count(8'd0);
        t_frac_count(8'd1);
        t_frac_count(8'd3);
        t_frac_count(8'd128);
        t_frac_count(8'd177);
        t_frac_count(8'd255);
        t_norm_period(8'd0);
        t_norm_period(8'd1);
        t_norm_period(8'd128);
        t_norm_period(8'd255);
        t_enable();
        t_mode_switch();
        t_load();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule